// File: doc/BRIEF.md
# DMA Transfer Byte Counter

This block keeps the byte count for a DMA data-transfer engine. Software reaches it over a small 8-bit register bus that has a chip select, separate read and write strobes, a 4-bit address and a bank-select input. Three byte-wide count registers are written into shadow storage. A DMA start command copies the shadow value into a working down-counter. The working counter then drops by one for every byte the engine reports as moved, and a terminal-count output rises when it reaches zero.

The shadow value is kept apart from the working counter. Equal-sized blocks can therefore be repeated with one start command each, and software can prepare the next count while the current transfer is still running. A loaded value of zero means the largest possible length. A feature input and a high-byte-enable input choose between a 16-bit and a 24-bit count. Reads of the count addresses never return the shadow contents. They return the bytes of the working counter.

Top module: `dma_xfer_counter`

## Requirements
- R1: A write with `bus_sel_n` and `bus_wr_n` both low stores `bus_wdata` into a shadow byte. Address 0x0 stores count bits [7:0] and address 0x1 stores bits [15:8], in either bank. Address 0xE stores bits [23:16] only when `bank_sel` is 0; with `bank_sel` at 1 that write leaves the shadow unchanged.
- R2: While `bus_sel_n` is high, strobes have no effect on the shadow and `bus_rdata` is zero.
- R3: A shadow write, and any cycle with neither `dma_start` nor `byte_done`, leaves the working counter unchanged, including while a transfer is running.
- R4: Each `dma_start` reloads the working counter from the unchanged shadow value, so repeated starts give equal counts without new writes.
- R5: When `wide_en & hi_en` is 0, a start loads shadow bits [15:8] and [7:0] only. A zero in those bits loads 65536.
- R6: When `wide_en & hi_en` is 1, a start loads all 24 shadow bits. A zero value loads 16,777,216.
- R7: A `byte_done` pulse with a nonzero working count lowers that count by one. At zero, `tc` is high and `byte_done` changes nothing, so the count does not wrap.
- R8: `tc` is low in the cycle after any start, including a start that loads zero.
- R9: A read in bank 0 at address 0x0, 0x1 or 0xE returns working count bits [7:0], [15:8] or [23:16]. Every other address, and 0xE in bank 1, reads zero.
- R10: Reset clears the working counter to zero, so `tc` is 1. Reset leaves the shadow bytes as they were.
- R11: When `dma_start` and `byte_done` arrive in the same cycle, the load wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| bus_sel_n | input | 1 | Register bus chip select, active low |
| bus_rd_n | input | 1 | Read strobe, active low |
| bus_wr_n | input | 1 | Write strobe, active low |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational) |
| bank_sel | input | 1 | Register bank for addresses 0x8 to 0xF |
| wide_en | input | 1 | Feature enable for extended counting |
| hi_en | input | 1 | Enables the count high byte |
| dma_start | input | 1 | DMA command: load the working counter from the shadow |
| byte_done | input | 1 | One byte transferred |
| tc | output | 1 | Terminal count: working counter is zero |

## Verification
The hardest state to reach is a 24-bit zero load. Its value of 2^24 cannot be read back through the byte-wide bus, and counting it down would take far too long. The bench proves the load happened by checking that `tc` stays low after the start and that a single `byte_done` leaves 0xFFFFFF. The 16-bit zero load is checked the same way, and its 65536 also shows up in the high read byte. Shadow independence is tested by rewriting all three count bytes halfway through a running count. The bench then reads back the untouched working value and checks that the next start picks up the new one.

// File: rtl/dxc_pkg.sv
`timescale 1ns/1ps
package dxc_pkg;
  // Address of shadow/readback byte i; the top byte sits in the banked half.
  function automatic logic [3:0] byte_addr(input int i, input int nbytes);
    if (i == nbytes - 1) return 4'hE;
    return 4'(i);
  endfunction

  // Banked addresses (upper half) only decode when bank 0 is selected.
  function automatic logic addr_banked(input logic [3:0] a);
    return a[3];
  endfunction
endpackage

// File: rtl/dxc_decode.sv
`timescale 1ns/1ps
module dxc_decode #(
  parameter int NBYTES = 3
) (
  input  logic              sel_n,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic [3:0]        addr,
  input  logic              bank,
  output logic [NBYTES-1:0] wr_en,
  output logic [NBYTES-1:0] rd_en
);
  import dxc_pkg::*;

  logic access;
  assign access = ~sel_n;

  for (genvar i = 0; i < NBYTES; i++) begin : g_byte
    logic hit;
    always_comb begin
      hit = (addr == byte_addr(i, NBYTES));
      if (addr_banked(addr) && bank) hit = 1'b0;
    end
    assign wr_en[i] = access & ~wr_n & hit;
    assign rd_en[i] = access & ~rd_n & hit;
  end
endmodule

// File: rtl/dxc_shadow.sv
`timescale 1ns/1ps
module dxc_shadow #(
  parameter int BYTE_W = 8,
  parameter int NBYTES = 3,
  localparam int W = BYTE_W * NBYTES
) (
  input  logic              clk,
  input  logic [NBYTES-1:0] wr_en,
  input  logic [BYTE_W-1:0] wdata,
  output logic [W-1:0]      value
);
  // No reset on purpose: the count survives any reset.
  for (genvar i = 0; i < NBYTES; i++) begin : g_byte
    logic [BYTE_W-1:0] q;
    always_ff @(posedge clk) begin
      if (wr_en[i]) q <= wdata;
    end
    assign value[i*BYTE_W +: BYTE_W] = q;
  end
endmodule

// File: rtl/dxc_work_counter.sv
`timescale 1ns/1ps
module dxc_work_counter #(
  parameter int W       = 24,
  parameter int SHORT_W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] shadow,
  input  logic         long_mode,
  input  logic         start,
  input  logic         step,
  output logic [W:0]   cnt,
  output logic         tc
);
  logic [W:0] cnt_q, cnt_d, load_val;
  logic       at_zero;

  assign at_zero = (cnt_q == '0);

  always_comb begin
    if (long_mode) begin
      if (shadow == '0) load_val = (W+1)'(1) << W;
      else              load_val = {1'b0, shadow};
    end else begin
      if (shadow[SHORT_W-1:0] == '0) load_val = (W+1)'(1) << SHORT_W;
      else                           load_val = (W+1)'(shadow[SHORT_W-1:0]);
    end
  end

  always_comb begin
    cnt_d = cnt_q;
    if (start)                  cnt_d = load_val;
    else if (step && !at_zero)  cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;
  assign tc  = at_zero;
endmodule

// File: rtl/dma_xfer_counter.sv
`timescale 1ns/1ps
module dma_xfer_counter #(
  parameter int BYTE_W = 8,
  parameter int NBYTES = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel_n,
  input  logic              bus_rd_n,
  input  logic              bus_wr_n,
  input  logic [3:0]        bus_addr,
  input  logic [BYTE_W-1:0] bus_wdata,
  output logic [BYTE_W-1:0] bus_rdata,
  input  logic              bank_sel,
  input  logic              wide_en,
  input  logic              hi_en,
  input  logic              dma_start,
  input  logic              byte_done,
  output logic              tc
);
  localparam int W       = BYTE_W * NBYTES;
  localparam int SHORT_W = 2 * BYTE_W;

  // Reset: asserted asynchronously, released through two flops.
  logic [1:0] rst_pipe;
  logic       rst_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_q = rst_pipe[1];

  logic [NBYTES-1:0] wr_en, rd_en;
  logic [W-1:0]      shadow_val;
  logic [W:0]        work_cnt;
  logic              long_mode;

  assign long_mode = wide_en & hi_en;

  dxc_decode #(.NBYTES(NBYTES)) u_dec (
    .sel_n (bus_sel_n),
    .rd_n  (bus_rd_n),
    .wr_n  (bus_wr_n),
    .addr  (bus_addr),
    .bank  (bank_sel),
    .wr_en (wr_en),
    .rd_en (rd_en)
  );

  dxc_shadow #(.BYTE_W(BYTE_W), .NBYTES(NBYTES)) u_shadow (
    .clk   (clk),
    .wr_en (wr_en),
    .wdata (bus_wdata),
    .value (shadow_val)
  );

  dxc_work_counter #(.W(W), .SHORT_W(SHORT_W)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_q),
    .shadow    (shadow_val),
    .long_mode (long_mode),
    .start     (dma_start),
    .step      (byte_done),
    .cnt       (work_cnt),
    .tc        (tc)
  );

  // Readback returns working-count bytes, never the shadow.
  always_comb begin
    bus_rdata = '0;
    for (int i = 0; i < NBYTES; i++) begin
      if (rd_en[i]) bus_rdata = bus_rdata | work_cnt[i*BYTE_W +: BYTE_W];
    end
  end
endmodule

// File: rtl/dxc_chk.sv
`timescale 1ns/1ps
module dxc_chk #(
  parameter int W = 24
) (
  input logic       clk,
  input logic       rst_q,
  input logic       dma_start,
  input logic       byte_done,
  input logic       bus_sel_n,
  input logic [7:0] bus_rdata,
  input logic [W:0] cnt,
  input logic       tc
);
  AST_DEC_BY_ONE: assert property (@(posedge clk) disable iff (!rst_q)
    (byte_done && !dma_start && !tc) |=> (cnt == $past(cnt) - 1'b1)); // R7
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_q)
    (!byte_done && !dma_start) |=> $stable(cnt)); // R3
  AST_TC_STICKY: assert property (@(posedge clk) disable iff (!rst_q)
    (tc && !dma_start) |=> tc); // R7
  AST_START_NO_TC: assert property (@(posedge clk) disable iff (!rst_q)
    dma_start |=> !tc); // R8
  AST_QUIET_BUS: assert property (@(posedge clk) disable iff (!rst_q)
    bus_sel_n |-> (bus_rdata == 8'h00)); // R2
endmodule

bind dma_xfer_counter dxc_chk #(.W(BYTE_W * NBYTES)) u_chk (
  .clk       (clk),
  .rst_q     (rst_q),
  .dma_start (dma_start),
  .byte_done (byte_done),
  .bus_sel_n (bus_sel_n),
  .bus_rdata (bus_rdata),
  .cnt       (work_cnt),
  .tc        (tc)
);

// File: tb/tb_dma_xfer_counter.sv
`timescale 1ns/1ps
module tb_dma_xfer_counter;
  logic       clk = 1'b0;
  logic       rst_n, bus_sel_n, bus_rd_n, bus_wr_n, bank_sel, wide_en, hi_en;
  logic       dma_start, byte_done, tc;
  logic [3:0] bus_addr;
  logic [7:0] bus_wdata, bus_rdata;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  dma_xfer_counter dut (
    .clk(clk), .rst_n(rst_n), .bus_sel_n(bus_sel_n), .bus_rd_n(bus_rd_n),
    .bus_wr_n(bus_wr_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bank_sel(bank_sel), .wide_en(wide_en),
    .hi_en(hi_en), .dma_start(dma_start), .byte_done(byte_done), .tc(tc)
  );

  // {wide_en, hi_en, shadow[23:0], expected readback[23:0]}
  localparam int NVEC = 6;
  localparam logic [49:0] VEC [NVEC] = '{
    {2'b00, 24'h123456, 24'h003456},
    {2'b00, 24'h000000, 24'h010000},
    {2'b11, 24'hABCDEF, 24'hABCDEF},
    {2'b10, 24'h7F0010, 24'h000010},
    {2'b11, 24'h000000, 24'h000000},
    {2'b01, 24'h00FFFF, 24'h00FFFF}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [3:0] a, input logic [7:0] d, input logic bk, input logic sel_n = 1'b0);
    @(negedge clk);
    bank_sel = bk; bus_addr = a; bus_wdata = d; bus_sel_n = sel_n; bus_wr_n = 1'b0;
    @(negedge clk);
    bus_sel_n = 1'b1; bus_wr_n = 1'b1; bank_sel = 1'b0;
  endtask

  task automatic bus_rd(input logic [3:0] a, input logic bk, output logic [7:0] d, input logic sel_n = 1'b0);
    bank_sel = bk; bus_addr = a; bus_sel_n = sel_n; bus_rd_n = 1'b0;
    #1;
    d = bus_rdata;
    bus_sel_n = 1'b1; bus_rd_n = 1'b1; bank_sel = 1'b0;
  endtask

  task automatic load_shadow(input logic [23:0] v);
    bus_wr(4'h0, v[7:0], 1'b0);
    bus_wr(4'h1, v[15:8], 1'b0);
    bus_wr(4'hE, v[23:16], 1'b0);
  endtask

  task automatic read_cnt(output logic [23:0] v);
    logic [7:0] b0, b1, b2;
    @(negedge clk);
    bus_rd(4'h0, 1'b0, b0);
    bus_rd(4'h1, 1'b0, b1);
    bus_rd(4'hE, 1'b0, b2);
    v = {b2, b1, b0};
  endtask

  task automatic start(input logic also_step = 1'b0);
    @(negedge clk);
    dma_start = 1'b1; byte_done = also_step;
    @(negedge clk);
    dma_start = 1'b0; byte_done = 1'b0;
  endtask

  task automatic step(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); byte_done = 1'b1;
      @(negedge clk); byte_done = 1'b0;
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [23:0] v;
    logic [7:0]  b;
    rst_n = 1'b0; bus_sel_n = 1'b1; bus_rd_n = 1'b1; bus_wr_n = 1'b1;
    bus_addr = '0; bus_wdata = '0; bank_sel = 1'b0; wide_en = 1'b0; hi_en = 1'b0;
    dma_start = 1'b0; byte_done = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R10: reset state
    check("R10 tc after reset", 32'(tc), 32'd1);
    read_cnt(v);
    check("R10 count after reset", 32'(v), 32'h0);

    // Table walk: mode selection and zero-length loads (R5, R6, R8, R9)
    for (int i = 0; i < NVEC; i++) begin
      wide_en = VEC[i][49]; hi_en = VEC[i][48];
      load_shadow(VEC[i][47:24]);
      start();
      read_cnt(v);
      check((VEC[i][49] & VEC[i][48]) ? "R6 load value" : "R5 load value", 32'(v), 32'(VEC[i][23:0]));
      check("R8 tc low after start", 32'(tc), 32'd0);
    end

    // R6: 24-bit zero load counts from 2^24
    wide_en = 1'b1; hi_en = 1'b1;
    load_shadow(24'h000000);
    start();
    step(1);
    read_cnt(v);
    check("R6 zero load minus one", 32'(v), 32'hFFFFFF);

    // R5: 16-bit zero load counts from 65536, high byte ignored
    wide_en = 1'b0; hi_en = 1'b1;
    load_shadow(24'h550000);
    start();
    check("R8 tc after zero load", 32'(tc), 32'd0);
    step(1);
    read_cnt(v);
    check("R5 zero load minus one", 32'(v), 32'h00FFFF);

    // R7: decrement to zero, then hold
    load_shadow(24'h000003);
    start();
    step(1); read_cnt(v); check("R7 count 2", 32'(v), 32'h2);
    step(1); read_cnt(v); check("R7 count 1", 32'(v), 32'h1);
    check("R7 tc low at 1", 32'(tc), 32'd0);
    step(1); read_cnt(v); check("R7 count 0", 32'(v), 32'h0);
    check("R7 tc at 0", 32'(tc), 32'd1);
    step(2); read_cnt(v); check("R7 no wrap", 32'(v), 32'h0);

    // R4: repeat start reuses shadow
    start(); read_cnt(v); check("R4 reload", 32'(v), 32'h3);

    // R3: shadow rewrite during a running count
    load_shadow(24'h00000A);
    start(); step(1);
    load_shadow(24'h000020);
    read_cnt(v); check("R3 running count kept", 32'(v), 32'h9);
    start(); read_cnt(v); check("R4 new shadow loaded", 32'(v), 32'h20);

    // R11: start and byte_done together
    start(1'b1); read_cnt(v); check("R11 load wins", 32'(v), 32'h20);

    // R2: no chip select
    bus_wr(4'h0, 8'h77, 1'b0, 1'b1);
    start(); read_cnt(v); check("R2 write ignored", 32'(v), 32'h20);
    @(negedge clk); bus_rd(4'h0, 1'b0, b, 1'b1);
    check("R2 rdata zero", 32'(b), 32'h0);

    // R1: bank handling of shadow writes
    wide_en = 1'b1; hi_en = 1'b1;
    load_shadow(24'h010000);
    bus_wr(4'hE, 8'h55, 1'b1);
    bus_wr(4'h0, 8'h04, 1'b1);
    start(); read_cnt(v); check("R1 bank1 writes", 32'(v), 32'h010004);

    // R9: other addresses and bank 1 readback
    @(negedge clk); bus_rd(4'hE, 1'b1, b); check("R9 bank1 0xE reads zero", 32'(b), 32'h0);
    @(negedge clk); bus_rd(4'h5, 1'b0, b); check("R9 unmapped reads zero", 32'(b), 32'h0);
    @(negedge clk); bus_rd(4'h0, 1'b1, b); check("R9 low byte in bank1", 32'(b), 32'h04);

    // R10: reset keeps shadow, clears counter
    wide_en = 1'b0; hi_en = 1'b0;
    load_shadow(24'h000005);
    start();
    do_reset();
    check("R10 tc after second reset", 32'(tc), 32'd1);
    read_cnt(v); check("R10 counter cleared", 32'(v), 32'h0);
    start(); read_cnt(v); check("R10 shadow kept", 32'(v), 32'h5);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule